// File: doc/BRIEF.md
# Six-Source Programmable-Priority Interrupt Controller

This block collects interrupt requests from six sources, holds each one in a request register until it is serviced, and filters the held requests through a per-source mask and a global enable. When several eligible requests are pending at once, a priority encoder picks one winner. The order it uses is set at run time through a priority register. The winner's 3-bit source index is presented to the processor core together with an interrupt request line. The core accepts the interrupt by pulsing an acknowledge line.

The priority register treats the six sources as three pairs: pair A holds sources 0 and 1, pair B holds 2 and 3, and pair C holds 4 and 5. A 3-bit order code ranks the three pairs against each other. One swap bit per pair decides which member of that pair wins inside it. Software reaches four registers over a simple write-strobe bus with a combinational read port. Those registers hold the request bits, the mask, the priority configuration and the global enable.

The control path is a two-state machine:
- ST_IDLE: no interrupt is offered to the core.
- ST_REQ: the line `irq_o` is high and a latched vector is held.

There are three transitions:
- present: ST_IDLE to ST_REQ, taken when any eligible request exists.
- accept: ST_REQ to ST_IDLE, taken on acknowledge.
- withdraw: ST_REQ to ST_IDLE, taken when the latched source stops being eligible before it is acknowledged.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request, mask, priority and enable registers read 0, and `irq_o` is 0.
- R2: A source input that is high at a clock edge sets its request bit (bit i = source i at address 0). The bit stays set until it is acknowledged or overwritten by software.
- R3: Software reads and writes the request register at address 0. A source event in the same cycle as that write still sets its bit on top of the written value.
- R4: Source i can win only while mask bit i (address 1) is 1. With mask 0, no interrupt is raised.
- R5: With the global enable (address 3, bit 0) at 0, no interrupt is raised whatever is pending.
- R6: The winner follows the priority register at address 2, which has two fields:
  - Bits [2:0] hold the pair order. Code 0 gives A>B>C, 1 gives A>C>B, 2 gives B>A>C, 3 gives B>C>A, 4 gives C>A>B and 5 gives C>B>A. Codes 6 and 7 act as code 0.
  - Bits 3, 4 and 5 are the swap bits of pairs A, B and C. When a pair's swap bit is 1, its odd source beats its even one; when it is 0, the even source wins.
- R7: In ST_IDLE, once an eligible request is held in the registers, `irq_o` rises at the next clock edge. At the same moment `irq_vec_o` gives the winning source index 0..5.
- R8: While `irq_o` stays high, `irq_vec_o` does not change, even if the priority register or other requests change.
- R9: An acknowledge while `irq_o` is high does three things at that edge: it clears only the presented source's request bit, it clears the global enable, and it lowers `irq_o`.
- R10: A source event in the same cycle as an acknowledge is kept. This holds even for the source being acknowledged.
- R11: If the presented source stops being eligible while `irq_o` is high, `irq_o` falls one edge later with no acknowledge. Its request bit is left set. A source stops being eligible when it is masked, cleared, or the enable is cleared.
- R12: An acknowledge while `irq_o` is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | 6 | Request events, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 request, 1 mask, 2 priority, 3 enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 3 | Winning source index |
| irq_ack_i | input | 1 | Acknowledge from the core |

## Verification
The hardest case to reach from the ports is the edge where an acknowledge meets a fresh event from the very source being cleared. Here the clear and the set fight over one flip-flop, and only the set may win. A close second is reprogramming priority, mask or enable while a vector is on offer. The bench reaches both states through directed sequences: it first drives the machine into ST_REQ, then lines up the acknowledge, the source pulse or the register write on one chosen edge. Priority resolution itself is covered by a full sweep of all 64 priority settings against all 63 non-empty request patterns.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int NUM_GRP = NUM_SRC / 2;
    localparam int VEC_W   = $clog2(NUM_SRC);
    localparam int GID_W   = 2;
    localparam int ORD_W   = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_REQ  = 2'd0,
        RA_MASK = 2'd1,
        RA_PRIO = 2'd2,
        RA_CTRL = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic [NUM_GRP-1:0] swap;
        logic [ORD_W-1:0]   order;
    } prio_cfg_t;

    // Packed {third, second, first} pair ids for an order code.
    function automatic logic [NUM_GRP*GID_W-1:0] group_rank(input logic [ORD_W-1:0] code);
        logic [NUM_GRP*GID_W-1:0] r;
        case (code)
            3'd1:    r = {2'd1, 2'd2, 2'd0};
            3'd2:    r = {2'd2, 2'd0, 2'd1};
            3'd3:    r = {2'd0, 2'd2, 2'd1};
            3'd4:    r = {2'd1, 2'd0, 2'd2};
            3'd5:    r = {2'd0, 2'd1, 2'd2};
            default: r = {2'd2, 2'd1, 2'd0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_o
);
    logic [N-1:0] req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= (wr_i ? wdata_i : (req_q & ~clr_i)) | src_i;
        end
    end

    assign req_o = req_q;

    // R10 / R2: an event is never lost, whatever else happens that cycle
    a_r10_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((req_o & $past(src_i)) == $past(src_i)));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]     pend_i,
    input  prio_cfg_t        cfg_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     grant_o
);
    localparam int G = N / 2;

    logic [G-1:0] gpend;
    logic [G-1:0] gsel;

    for (genvar g = 0; g < G; g++) begin : g_pair
        assign gpend[g] = pend_i[2*g] | pend_i[2*g+1];
        assign gsel[g]  = cfg_i.swap[g] ? pend_i[2*g+1] : ~pend_i[2*g];
    end

    always_comb begin
        logic [G*GID_W-1:0] rank;
        logic [GID_W-1:0]   gid;
        rank  = group_rank(cfg_i.order);
        any_o = 1'b0;
        vec_o = '0;
        for (int k = G - 1; k >= 0; k--) begin
            gid = rank[k*GID_W +: GID_W];
            if (gpend[gid]) begin
                any_o = 1'b1;
                vec_o = VEC_W'({gid, gsel[gid]});
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_grant
        assign grant_o[i] = any_o && (vec_o == VEC_W'(i));
    end

    always_comb begin
        a_r6_grant_onehot: assert ($onehot0(grant_o));
        a_r6_grant_pending: assert ((grant_o & ~pend_i) == '0);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_evt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    input  logic              irq_ack_i
);
    localparam int CFG_W = $bits(prio_cfg_t);

    irq_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] req_q, mask_q, pend, clr, grant;
    prio_cfg_t          cfg_q;
    logic               gen_q;
    logic [VEC_W-1:0]   vec_q, win_vec;
    logic               win_any, ack_take;
    logic               wr_req, wr_mask, wr_prio, wr_ctrl;

    assign wr_req  = reg_wr_i && (reg_addr_i == RA_REQ);
    assign wr_mask = reg_wr_i && (reg_addr_i == RA_MASK);
    assign wr_prio = reg_wr_i && (reg_addr_i == RA_PRIO);
    assign wr_ctrl = reg_wr_i && (reg_addr_i == RA_CTRL);

    assign ack_take = (state_q == ST_REQ) && irq_ack_i;
    assign pend     = req_q & mask_q & {NUM_SRC{gen_q}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr[i] = ack_take && (vec_q == VEC_W'(i));
    end

    irq_req_latch #(.N(NUM_SRC)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_evt_i),
        .wr_i    (wr_req),
        .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
        .clr_i   (clr),
        .req_o   (req_q)
    );

    irq_prio_resolve #(.N(NUM_SRC)) u_res (
        .pend_i  (pend),
        .cfg_i   (cfg_q),
        .any_o   (win_any),
        .vec_o   (win_vec),
        .grant_o (grant)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= '0;
            gen_q  <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
            if (wr_prio) cfg_q  <= prio_cfg_t'(reg_wdata_i[CFG_W-1:0]);
            if (wr_ctrl)       gen_q <= reg_wdata_i[0];
            else if (ack_take) gen_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_any) state_d = ST_REQ;
            ST_REQ: begin
                if (irq_ack_i)         state_d = ST_IDLE;
                else if (!pend[vec_q]) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q == ST_IDLE && win_any) begin
            vec_q <= win_vec;
        end
    end

    assign irq_o     = (state_q == ST_REQ);
    assign irq_vec_o = vec_q;

    always_comb begin
        unique case (reg_addr_i)
            RA_REQ:  reg_rdata_o = DATA_W'(req_q);
            RA_MASK: reg_rdata_o = DATA_W'(mask_q);
            RA_PRIO: reg_rdata_o = DATA_W'(cfg_q);
            RA_CTRL: reg_rdata_o = DATA_W'(gen_q);
        endcase
    end

    a_r8_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> (irq_vec_o == $past(irq_vec_o)));
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_ack_i) |=> !irq_o);
    a_r9_ack_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_ack_i && !wr_ctrl) |=> !gen_q);
    a_r5_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(gen_q));
    a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec_o < VEC_W'(NUM_SRC)));
    a_r12_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && irq_ack_i && !reg_wr_i && !(|src_evt_i)) |=> (req_q == $past(req_q)));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_evt = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [2:0] irq_vec;
    logic       irq_ack = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq), .irq_vec_o(irq_vec),
        .irq_ack_i(irq_ack)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 2'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        cyc();
        irq_ack = 1'b0;
    endtask

    // Expected winner, computed from the priority rules; -1 if none.
    function automatic int model_win(input int pat, input int prio);
        int order, first, a, b, second, third, best, bestkey;
        int pos[3];
        order = prio & 7;
        if (order > 5) order = 0;
        first = order / 2;
        a = (first == 0) ? 1 : 0;
        b = (first == 2) ? 1 : 2;
        second = (order % 2 == 0) ? a : b;
        third = 3 - first - second;
        pos[first] = 0; pos[second] = 1; pos[third] = 2;
        best = -1; bestkey = 99;
        for (int s = 0; s < 6; s++) begin
            if (((pat >> s) & 1) == 1) begin
                int g, w, key;
                g = s / 2;
                w = s % 2;
                if (((prio >> (3 + g)) & 1) == 1) w = 1 - w;
                key = pos[g] * 2 + w;
                if (key < bestkey) begin bestkey = key; best = s; end
            end
        end
        return best;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int v;
        @(negedge clk);
        cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v); chk("R1 reg reset", v, 0);
        end
        chk("R1 irq reset", int'(irq), 0);

        // R2 event latching
        src_evt = 6'b000100; cyc(); src_evt = '0;
        rd(0, v); chk("R2 event latched", v, 4);
        cyc(); rd(0, v); chk("R2 bit held", v, 4);

        // R3 software write with simultaneous event
        src_evt = 6'b100000;
        wr(0, 1);
        src_evt = '0;
        rd(0, v); chk("R3 write plus event", v, 33);
        wr(0, 0); rd(0, v); chk("R3 write zero", v, 0);

        // R5 enable gating
        wr(1, 63); wr(0, 1);
        cyc(); cyc(); cyc();
        chk("R5 no irq without enable", int'(irq), 0);

        // R4 mask zero blocks everything
        wr(1, 0); wr(3, 1);
        cyc(); cyc(); cyc();
        chk("R4 mask zero no irq", int'(irq), 0);
        wr(3, 0);

        // R4 masked winner skipped
        wr(1, 62); wr(2, 0); wr(0, 63); wr(3, 1);
        cyc();
        chk("R4 masked irq", int'(irq), 1);
        chk("R4 masked winner", int'(irq_vec), 1);
        ack();
        rd(0, v); chk("R9 only bit1 cleared", v, 61);

        // R7 timing from event to irq
        wr(1, 63); wr(0, 0); wr(3, 1);
        src_evt = 6'b100000; cyc(); src_evt = '0;
        chk("R7 irq not yet", int'(irq), 0);
        cyc();
        chk("R7 irq raised", int'(irq), 1);
        chk("R7 vector", int'(irq_vec), 5);
        ack();
        chk("R9 irq drops", int'(irq), 0);

        // R8 stability while presenting
        wr(0, 48); wr(2, 0); wr(3, 1);
        cyc();
        chk("R8 initial vec", int'(irq_vec), 4);
        wr(2, 32);
        chk("R8 vec after prio write", int'(irq_vec), 4);
        src_evt = 6'b000001; cyc(); src_evt = '0;
        chk("R8 vec after new event", int'(irq_vec), 4);
        chk("R8 irq held", int'(irq), 1);
        ack();
        rd(0, v); chk("R9 clear only presented", v, 33);
        rd(3, v); chk("R9 enable cleared", v, 0);

        // R10 event on acknowledged source in the ack cycle
        wr(2, 0); wr(0, 8); wr(3, 1);
        cyc();
        chk("R10 vec", int'(irq_vec), 3);
        src_evt = 6'b001010; irq_ack = 1'b1;
        cyc();
        src_evt = '0; irq_ack = 1'b0;
        rd(0, v); chk("R10 events kept", v, 10);
        chk("R10 irq dropped", int'(irq), 0);

        // R11 withdraw by masking
        wr(0, 4); wr(3, 1);
        cyc();
        chk("R11 presenting", int'(irq), 1);
        wr(1, 59);
        chk("R11 still high one edge", int'(irq), 1);
        cyc();
        chk("R11 withdrawn by mask", int'(irq), 0);
        rd(0, v); chk("R11 bit kept", v, 4);
        // R11 withdraw by enable clear
        wr(1, 63);
        cyc();
        chk("R11 re-presented", int'(irq), 1);
        wr(3, 0);
        cyc();
        chk("R11 withdrawn by enable", int'(irq), 0);
        rd(0, v); chk("R11 bit kept again", v, 4);

        // R12 ack while idle
        ack();
        rd(0, v); chk("R12 req untouched", v, 4);
        rd(3, v); chk("R12 enable untouched", v, 0);
        wr(3, 1); wr(3, 0);
        cyc();
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd(0, v); chk("R12 req after idle ack", v, 4);

        // R6 exhaustive priority sweep
        wr(1, 63);
        for (int p = 0; p < 64; p++) begin
            wr(2, p);
            for (int pat = 1; pat < 64; pat++) begin
                int w;
                w = model_win(pat, p);
                wr(0, pat); wr(3, 1);
                cyc();
                chk("R6 irq", int'(irq), 1);
                chk("R6 winner", int'(irq_vec), w);
                ack();
                rd(0, v); chk("R9 sweep clear", v, pat & ~(1 << w));
                rd(3, v); chk("R9 sweep enable", v, 0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule